// File: doc/BRIEF.md
# Active Tamper Pattern Generator

This block drives pseudo-random levels onto a set of active tamper outputs and checks that the matching inputs return the same levels. If a wire is cut, shorted or forced, the input no longer follows its pattern and the block reports a tamper event on that channel. The patterns come from a 128-bit linear feedback shift register. Software seeds it by writing four 32-bit words in sequence, and the block reports both when a word is still being absorbed and when the generator is fully seeded and running.

The pattern rate is set by two fields. A divider select picks the prescaled tick rate as a power-of-two fraction of the block clock. A period field sets how many prescaled ticks the pattern is held before it advances. The divider select can only be changed while every channel is off, and it stays locked for a short guard time after the last channel is disabled. Each input is compared either with its own output or, when sharing is on, with any output chosen by a per-channel selection field. This lets one output drive several loops. The low byte of the generator state is readable at all times.

Top module: `atp_pattern_gen`

## Requirements
- R1: Each pulse on `seed_wr` latches `seed_word`. On the following clock edge the word is XORed into one 32-bit quarter of the 128-bit state: quarter i occupies state bits [32i+31:32i]. The quarter index starts at 0, increases by one per absorbed word, wraps after 3, and is held at 0 on every edge at which no channel is enabled.
- R2: `seed_busy` is high for exactly the clock cycle that follows a clock edge with `seed_wr` high, and is low otherwise.
- R3: `init_done` rises on the edge that absorbs the word for quarter 3 while a channel is enabled. It falls on the first edge at which no channel is enabled.
- R4: Number the clock edges since the channels were last all disabled, starting at 0. A prescaled tick occurs at an edge j when j mod 2^N = 2^N-1, where N is `div_sel`. The pattern advances at an edge j when j mod 2^(N+P) = 2^(N+P)-1, where P is `period_sel`. The pattern advances only while `init_done` is high.
- R5: An advance shifts the state left by one bit. The new bit 0 is the XOR of state bits 127, 125, 100 and 98. When a seed word is absorbed at the same edge, the XOR is applied to the shifted state. `gen_value` always equals state bits [7:0].
- R6: `tamp_out[k]` equals state bit k when channel k is enabled through `tamper_en[k]`, and 0 when it is disabled.
- R7: A write through `div_wr` loads `div_wdata` into `div_sel` only when it is sampled with no channel enabled. The write is ignored at the first 2^(N+1)+1 edges after the edge at which the last channel was seen enabled.
- R8: When `share_en` is 0, input k is compared with `tamp_out[k]`. When `share_en` is 1, input k is compared with `tamp_out[s]`, where s is `share_sel[3k+2:3k]`.
- R9: The compare is made once per advance, at the first prescaled tick after the advance edge, and only while `init_done` is high. It uses the values present just before that edge. `tamper_evt[k]` then pulses for one cycle if channel k is enabled and its input differs from its expected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_en | input | 8 | Per-channel active tamper enable |
| seed_wr | input | 1 | Seed word write strobe |
| seed_word | input | 32 | Seed word data |
| div_wr | input | 1 | Divider select write strobe |
| div_wdata | input | 3 | Divider select write data |
| period_sel | input | 3 | Pattern hold period exponent P |
| share_en | input | 1 | Compare inputs against selected shared outputs |
| share_sel | input | 24 | Per-input output selection, 3 bits per channel |
| tamp_in | input | 8 | Returned tamper loop inputs |
| tamp_out | output | 8 | Pattern drive outputs |
| div_sel | output | 3 | Current divider select N |
| seed_busy | output | 1 | Seed word absorption pending |
| init_done | output | 1 | Full seed absorbed and generator running |
| gen_value | output | 8 | Low byte of generator state |
| tamper_evt | output | 8 | One-cycle mismatch event per channel |

## Verification
The hardest case to reach from the ports is the guard time on the divider select. It depends on both the previous select value and the exact edge at which the last enable was dropped. The bench disables all channels, counts edges from that point, and places one write on the last blocked edge and another on the first permitted edge. It does this for every divider value in the sweep. The compare instant is also awkward: it moves with N and P and depends on when the advance happened. So the bench keeps its own edge count and state model across a sweep of divider and period values, with sharing both on and off, and drives the returned inputs from that model with deliberate bit flips.

// File: rtl/atp_pkg.sv
package atp_pkg;
  localparam int unsigned ST_W    = 128;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = ST_W / WORD_W;
  localparam int unsigned Q_W     = $clog2(N_WORDS);
  localparam int unsigned GEN_W   = 8;

  localparam logic [ST_W-1:0] TAP_MASK =
    (ST_W'(1) << 127) | (ST_W'(1) << 125) | (ST_W'(1) << 100) | (ST_W'(1) << 98);

  // One Fibonacci step: shift left, feed parity of tapped bits into bit 0.
  function automatic logic [ST_W-1:0] lfsr_advance(input logic [ST_W-1:0] s);
    return {s[ST_W-2:0], ^(s & TAP_MASK)};
  endfunction

  // Seed word placed at its quarter of the state.
  function automatic logic [ST_W-1:0] place_word(input logic [WORD_W-1:0] w,
                                                 input logic [Q_W-1:0] q);
    return ST_W'(w) << (int'(q) * WORD_W);
  endfunction
endpackage

// File: rtl/atp_timebase.sv
module atp_timebase #(
  parameter int DIV_W = 3,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_en,
  input  logic             sel_wr,
  input  logic [DIV_W-1:0] sel_wdata,
  input  logic [PER_W-1:0] period,
  output logic [DIV_W-1:0] div_sel,
  output logic             pre_tick,
  output logic             pat_tick
);
  localparam int CNT_W = (1 << DIV_W) - 1 + (1 << PER_W) - 1;
  localparam int GD_W  = (1 << DIV_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [GD_W-1:0]  guard_q;
  logic             en_q;
  logic             sel_ok;

  // True when the low k bits of c are all ones (k = CNT_W gives the full mask).
  function automatic logic low_ones(input logic [CNT_W-1:0] c, input int k);
    logic [CNT_W-1:0] m;
    m = (CNT_W'(1) << k) - CNT_W'(1);
    return (c & m) == m;
  endfunction

  assign pre_tick = any_en && low_ones(cnt_q, int'(div_sel));
  assign pat_tick = any_en && low_ones(cnt_q, int'(div_sel) + int'(period));
  assign sel_ok   = !any_en && !en_q && (guard_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      en_q    <= 1'b0;
      guard_q <= '0;
      div_sel <= '0;
    end else begin
      cnt_q <= any_en ? cnt_q + CNT_W'(1) : '0;
      en_q  <= any_en;
      if (en_q && !any_en)
        guard_q <= GD_W'(1) << ({1'b0, div_sel} + 4'd1);
      else if (guard_q != '0)
        guard_q <= guard_q - GD_W'(1);
      if (sel_wr && sel_ok)
        div_sel <= sel_wdata;
    end
  end

  // R7: divider select frozen while any channel is (or just was) enabled
  a_r7_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en || en_q) |=> $stable(div_sel));

  // R4: a pattern advance always coincides with a prescaled tick
  a_r4_pat_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pat_tick |-> pre_tick);
endmodule

// File: rtl/atp_prng.sv
module atp_prng
  import atp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_en,
  input  logic              seed_wr,
  input  logic [WORD_W-1:0] seed_word,
  input  logic              step,
  output logic [ST_W-1:0]   state,
  output logic              busy,
  output logic              init
);
  logic [WORD_W-1:0] pend_q;
  logic [Q_W-1:0]    q_idx;
  logic              absorb;
  logic [ST_W-1:0]   stepped;
  logic              last_quarter;

  assign absorb       = busy;
  assign stepped      = step ? lfsr_advance(state) : state;
  assign last_quarter = (q_idx == Q_W'(N_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= '0;
      pend_q <= '0;
      busy   <= 1'b0;
      q_idx  <= '0;
      init   <= 1'b0;
    end else begin
      busy <= seed_wr;
      if (seed_wr) pend_q <= seed_word;
      state <= absorb ? (stepped ^ place_word(pend_q, q_idx)) : stepped;
      if (!any_en) begin
        q_idx <= '0;
        init  <= 1'b0;
      end else if (absorb) begin
        q_idx <= q_idx + Q_W'(1);
        if (last_quarter) init <= 1'b1;
      end
    end
  end

  // R2: busy lasts one cycle unless a new word follows
  a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seed_wr) |=> !busy);

  // R3: disabling all channels drops the initialized flag
  a_r3_init_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !init);

  // R3: the flag only rises on an absorption edge
  a_r3_init_on_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init) |-> $past(busy));

  // R4: state never advances before initialization without a seed word
  a_r4_no_step_uninit: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !busy) |=> $stable(state));
endmodule

// File: rtl/atp_compare.sv
module atp_compare #(
  parameter int NCH   = 8,
  parameter int SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       en,
  input  logic                 share,
  input  logic [NCH*SEL_W-1:0] sel,
  input  logic [NCH-1:0]       pat,
  input  logic [NCH-1:0]       tin,
  input  logic                 pre_tick,
  input  logic                 step,
  input  logic                 init,
  output logic [NCH-1:0]       evt
);
  logic [NCH-1:0] expect_v;
  logic           armed_q;
  logic           compare;

  for (genvar k = 0; k < NCH; k++) begin : g_map
    logic [SEL_W-1:0] idx;
    assign idx         = sel[k*SEL_W +: SEL_W];
    assign expect_v[k] = share ? ((int'(idx) < NCH) ? pat[idx] : 1'b0) : pat[k];
  end

  assign compare = armed_q && pre_tick && init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      evt     <= '0;
    end else begin
      if (!init)         armed_q <= 1'b0;
      else if (step)     armed_q <= 1'b1;
      else if (pre_tick) armed_q <= 1'b0;
      evt <= compare ? ((tin ^ expect_v) & en) : '0;
    end
  end

  // R9: no event unless the generator was initialized
  a_r9_evt_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> $past(init));

  // R9: events only on channels that were enabled
  a_r9_evt_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> ((evt & ~$past(en)) == '0));
endmodule

// File: rtl/atp_pattern_gen.sv
module atp_pattern_gen
  import atp_pkg::*;
#(
  parameter  int NCH   = 8,
  parameter  int DIV_W = 3,
  parameter  int PER_W = 3,
  localparam int SEL_W = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       tamper_en,
  input  logic                 seed_wr,
  input  logic [WORD_W-1:0]    seed_word,
  input  logic                 div_wr,
  input  logic [DIV_W-1:0]     div_wdata,
  input  logic [PER_W-1:0]     period_sel,
  input  logic                 share_en,
  input  logic [NCH*SEL_W-1:0] share_sel,
  input  logic [NCH-1:0]       tamp_in,
  output logic [NCH-1:0]       tamp_out,
  output logic [DIV_W-1:0]     div_sel,
  output logic                 seed_busy,
  output logic                 init_done,
  output logic [GEN_W-1:0]     gen_value,
  output logic [NCH-1:0]       tamper_evt
);
  logic            any_en;
  logic            pre_tick;
  logic            pat_tick;
  logic            step_fire;
  logic [ST_W-1:0] state;

  assign any_en    = |tamper_en;
  assign step_fire = pat_tick & init_done;
  assign tamp_out  = state[NCH-1:0] & tamper_en;
  assign gen_value = state[GEN_W-1:0];

  atp_timebase #(.DIV_W(DIV_W), .PER_W(PER_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .any_en(any_en),
    .sel_wr(div_wr), .sel_wdata(div_wdata), .period(period_sel),
    .div_sel(div_sel), .pre_tick(pre_tick), .pat_tick(pat_tick));

  atp_prng u_gen (
    .clk(clk), .rst_n(rst_n), .any_en(any_en),
    .seed_wr(seed_wr), .seed_word(seed_word), .step(step_fire),
    .state(state), .busy(seed_busy), .init(init_done));

  atp_compare #(.NCH(NCH), .SEL_W(SEL_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(tamper_en), .share(share_en),
    .sel(share_sel), .pat(tamp_out), .tin(tamp_in),
    .pre_tick(pre_tick), .step(step_fire), .init(init_done),
    .evt(tamper_evt));

  // R6: disabled channels never drive a one
  a_r6_out_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (tamp_out & ~tamper_en) == '0);
endmodule

// File: tb/sim_atp_pattern_gen.sv
`timescale 1ns/1ps
module sim_atp_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  en_d = '0;
  logic        seed_wr_d = 1'b0;
  logic [31:0] seed_d = '0;
  logic        div_wr_d = 1'b0;
  logic [2:0]  div_wd = '0;
  logic [2:0]  period_d = '0;
  logic        share_d = 1'b0;
  logic [23:0] sel_d;
  logic [7:0]  tin_d = '0;
  logic [7:0]  inj_d = '0;
  logic [7:0]  tamp_out;
  logic [2:0]  div_sel;
  logic        seed_busy, init_done;
  logic [7:0]  gen_value, tamper_evt;

  int checks = 0, fails = 0, n_evt = 0;
  int cur_n = 0;
  logic [127:0] m_st = '0;
  logic [31:0]  m_pend = '0;
  int  m_q = 0, m_cnt = 0;
  bit  m_init = 0, m_armed = 0, m_busy = 0;

  always #10 clk = ~clk;

  atp_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .tamper_en(en_d), .seed_wr(seed_wr_d),
    .seed_word(seed_d), .div_wr(div_wr_d), .div_wdata(div_wd),
    .period_sel(period_d), .share_en(share_d), .share_sel(sel_d),
    .tamp_in(tin_d), .tamp_out(tamp_out), .div_sel(div_sel),
    .seed_busy(seed_busy), .init_done(init_done), .gen_value(gen_value),
    .tamper_evt(tamper_evt));

  initial for (int k = 0; k < 8; k++) sel_d[3*k +: 3] = 3'((k + 3) % 8);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected input levels from the comparison rule (R8)
  function automatic logic [7:0] expect_map(input logic [7:0] outs);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = share_d ? outs[sel_d[3*k +: 3]] : outs[k];
    return r;
  endfunction

  function automatic logic [127:0] adv(input logic [127:0] s);
    logic fb;
    fb = s[127] ^ s[125] ^ s[100] ^ s[98];
    return {s[126:0], fb};
  endfunction

  function automatic void drive_tin();
    tin_d = expect_map(m_st[7:0] & en_d) ^ inj_d;
  endfunction

  // One clock: predict the edge from the requirements, then check at negedge.
  task automatic cyc();
    bit any, pt, at, stp, cmp;
    int pm, am;
    logic [7:0] eevt;
    logic [127:0] ns;
    any  = |en_d;
    pm   = 1 << cur_n;
    am   = 1 << (cur_n + int'(period_d));
    pt   = any && (m_cnt % pm == pm - 1);
    at   = any && (m_cnt % am == am - 1);
    stp  = at && m_init;
    cmp  = m_armed && pt && m_init;
    eevt = cmp ? ((tin_d ^ expect_map(m_st[7:0] & en_d)) & en_d) : 8'h00;
    ns = stp ? adv(m_st) : m_st;
    if (m_busy) ns = ns ^ (128'(m_pend) << (32 * m_q));
    m_st = ns;
    if (!m_init) m_armed = 0;
    else if (stp) m_armed = 1;
    else if (pt) m_armed = 0;
    if (!any) begin m_q = 0; m_init = 0; end
    else if (m_busy) begin
      if (m_q == 3) m_init = 1;
      m_q = (m_q + 1) % 4;
    end
    m_busy = seed_wr_d;
    m_pend = seed_d;
    m_cnt  = any ? ((m_cnt + 1) & 16383) : 0;
    @(posedge clk);
    @(negedge clk);
    chk("R4 R5 R1 gen_value", 32'(gen_value), 32'(m_st[7:0]));
    chk("R6 tamp_out", 32'(tamp_out), 32'(m_st[7:0] & en_d));
    chk("R2 seed_busy", 32'(seed_busy), 32'(m_busy));
    chk("R3 init_done", 32'(init_done), 32'(m_init));
    chk("R8 R9 tamper_evt", 32'(tamper_evt), 32'(eevt));
    if (tamper_evt != 0) n_evt++;
    drive_tin();
  endtask

  task automatic write_seed(input logic [31:0] w);
    seed_wr_d = 1'b1; seed_d = w;
    cyc();
    seed_wr_d = 1'b0;
  endtask

  // R7: disable all, hit last blocked edge, then first permitted edge
  task automatic set_div(input int n);
    int g;
    g = 1 << (cur_n + 1);
    en_d = 8'h00; drive_tin();
    repeat (g) cyc();
    div_wr_d = 1'b1; div_wd = 3'((cur_n + 1) % 8);
    cyc();
    chk("R7 write on last guarded edge ignored", 32'(div_sel), 32'(cur_n));
    div_wd = 3'(n);
    cyc();
    chk("R7 write after guard accepted", 32'(div_sel), 32'(n));
    div_wr_d = 1'b0;
    cur_n = n;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset gen_value", 32'(gen_value), 0);
    chk("R6 reset tamp_out", 32'(tamp_out), 0);
    chk("R3 reset init_done", 32'(init_done), 0);
    chk("R7 reset div_sel", 32'(div_sel), 0);
    rst_n = 1'b1;
    en_d = 8'hFF; drive_tin();
    repeat (3) cyc();
    for (int n = 0; n < 3; n++) begin
      for (int p = 0; p < 3; p++) begin
        int c;
        c = n * 3 + p;
        set_div(n);
        period_d = 3'(p);
        share_d  = c[0];
        inj_d    = 8'h00;
        en_d     = (c % 3 == 2) ? 8'hEF : 8'hFF;
        drive_tin();
        cyc();
        for (int i = 0; i < 4; i++) begin
          write_seed(32'h9E3779B9 * 32'(c * 4 + i + 1));
          if (i == 2) chk("R3 not ready after three words", 32'(init_done), 0);
        end
        cyc();
        chk("R3 ready after fourth word", 32'(init_done), 1);
        div_wr_d = 1'b1; div_wd = 3'((cur_n + 3) % 8);
        cyc();
        chk("R7 write ignored while enabled", 32'(div_sel), 32'(cur_n));
        div_wr_d = 1'b0;
        repeat (40) cyc();
        inj_d = 8'h11; drive_tin();
        repeat (40) cyc();
        inj_d = 8'h00; drive_tin();
        write_seed(32'hA5A5F00D + 32'(c));
        repeat (8) cyc();
      end
    end
    chk("R9 mismatch events observed", 32'(n_evt > 0), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule